// File: doc/BRIEF.md
# Dual-Issue Dispatch Dependency Checker

This block sits at the issue point of a two-way, in-order superscalar pipeline. Every cycle the fetch queue shows it its two oldest decoded instructions. Slot 0 holds the older one and slot 1 the younger. Each slot carries:

- a valid flag;
- a destination register index with a write enable;
- a set of source register indices, each with its own read enable;
- a flag that marks a memory access (load or store).

The checker decides whether both instructions can leave the queue together or whether only the older one can.

A pair is split in three cases:

- the younger instruction reads the register the older one writes;
- both instructions write the same register;
- both instructions access memory.

When a pair is split, the checker reports a consumed count of one. The queue then advances by one entry, so the held younger instruction appears in slot 0 on the next cycle and is paired with the next queued entry. Program order is kept throughout. Hazards against instructions that have already issued are left to the pipeline's forwarding network and are not examined here.

The consumed count is combinational, so the queue can advance in the same cycle. The issue decision and the issued instructions' destination, write-enable and memory flags are captured in a lane register. That register feeds the two execution lanes on the following cycle.

Top module: `dual_issue_dispatch`

## Requirements
- R1: Whenever slot 0 is valid and reset is not active, the older instruction issues on lane 0 (`lane_valid[0]`), and lane 1 never issues without lane 0.
- R2: Two valid, mutually independent instructions issue together: `consumed` = 2, and on the next cycle `lane_valid` = 2'b11 with `lane_rd[0]`/`lane_rd[1]` holding slot 0's and slot 1's destinations.
- R3: If any enabled source of slot 1 equals slot 0's destination while slot 0's write enable is set, only slot 0 issues (`consumed` = 1, `lane_valid` = 2'b01). This applies to either source position.
- R4: If both slots have write enable set and equal destinations, only slot 0 issues.
- R5: If both slots have the memory flag set, only slot 0 issues. A memory instruction paired with a non-memory instruction may dual-issue, and `lane_mem` then has at most one bit set.
- R6: If only slot 0 is valid (`slot_valid` = 2'b01), it issues alone in that cycle with `consumed` = 1, without waiting for a partner.
- R7: `consumed` reflects the current slot contents in the same cycle. The lane outputs change at the next rising clock edge.
- R8: While `rst_n` is low, `consumed` is 0. At a rising edge with `rst_n` low, `lane_valid`, `lane_wr_en` and `lane_mem` are cleared and `lane_rd` is zeroed.
- R9: If slot 0 is not valid, nothing issues and `consumed` is 0, even when slot 1 is valid.
- R10: A source whose read enable is low never creates a hazard. A slot 0 instruction whose write enable is low creates no read-after-write or write-after-write hazard.
- R11: Over a stream, a held younger instruction is re-paired in slot 0 on the next cycle. Six instructions in dependent pairing issue in four cycles (consumed 1,2,2,1). The same work reordered so that independent instructions sit side by side issues in three cycles (2,2,2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_valid | input | 2 | Slot holds an instruction; bit 0 = older, bit 1 = younger |
| slot_wr_en | input | 2 | Slot writes its destination register |
| slot_rd | input | 2 x REG_IDX_W | Destination register index per slot |
| slot_src_en | input | 2 x SRC_PER_INSTR | Source read enable per slot and source position |
| slot_src | input | 2 x SRC_PER_INSTR x REG_IDX_W | Source register index per slot and source position |
| slot_mem | input | 2 | Slot is a load or store |
| consumed | output | 2 | Entries the queue must pop this cycle (0, 1 or 2) |
| lane_valid | output | 2 | Lane carries an issued instruction (registered) |
| lane_rd | output | 2 x REG_IDX_W | Destination of the issued instruction per lane (registered) |
| lane_wr_en | output | 2 | Issued instruction writes a register (registered) |
| lane_mem | output | 2 | Issued instruction accesses memory (registered) |

## Verification
A wrong hazard flag or a wrong pairing choice shows first as a wrong `consumed` value in the same cycle the pair is presented. It shows one clock later as a wrong `lane_valid` pattern or a wrong lane destination. Because the queue pops by `consumed`, one misjudged pair also shifts every later pairing. The six-instruction streams therefore expose such an error in the very next cycle of the schedule table. A lane register that is not cleared shows as a stale `lane_valid` bit on the first edge after reset.

// File: rtl/dd_pkg.sv
// Package: shared types for the dual-issue dispatch checker.
// Assumes exactly two issue slots; slot 0 is always the older instruction.
package dd_pkg;

    // Outcome of examining the two queue heads in one cycle.
    typedef enum logic [2:0] {
        PK_IDLE      = 3'd0,  // nothing issues
        PK_SOLO      = 3'd1,  // only one instruction present, issues alone
        PK_SPLIT_RAW = 3'd2,  // younger reads older's destination
        PK_SPLIT_WAW = 3'd3,  // both write the same destination
        PK_SPLIT_MEM = 3'd4,  // both access memory
        PK_DUAL      = 3'd5   // both issue together
    } pair_kind_e;

    // Number of queue entries retired for a given outcome.
    function automatic logic [1:0] slots_taken(pair_kind_e k);
        case (k)
            PK_IDLE: slots_taken = 2'd0;
            PK_DUAL: slots_taken = 2'd2;
            default: slots_taken = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/dd_hazard.sv
// Module: dd_hazard
// Compares the younger instruction of a pair against the older one and
// flags read-after-write, write-after-write and dual memory access.
// Assumes: purely combinational, no knowledge of instructions already issued.
module dd_hazard #(
    parameter int REG_IDX_W     = 5,
    parameter int SRC_PER_INSTR = 2
) (
    input  logic                                    old_wr_en,
    input  logic [REG_IDX_W-1:0]                    old_rd,
    input  logic                                    old_mem,
    input  logic                                    yng_wr_en,
    input  logic [REG_IDX_W-1:0]                    yng_rd,
    input  logic [SRC_PER_INSTR-1:0]                yng_src_en,
    input  logic [SRC_PER_INSTR-1:0][REG_IDX_W-1:0] yng_src,
    input  logic                                    yng_mem,
    output logic                                    raw,
    output logic                                    waw,
    output logic                                    mem_clash
);

    logic [SRC_PER_INSTR-1:0] src_hit;

    // One comparator per source position of the younger instruction.
    for (genvar s = 0; s < SRC_PER_INSTR; s++) begin : g_src
        assign src_hit[s] = old_wr_en && yng_src_en[s] && (yng_src[s] == old_rd);
    end

    // Reduce comparator hits and check destination and memory overlap.
    always_comb begin
        raw       = |src_hit;
        waw       = old_wr_en && yng_wr_en && (old_rd == yng_rd);
        mem_clash = old_mem && yng_mem;
    end

endmodule

// File: rtl/dd_pair_classify.sv
// Module: dd_pair_classify
// Turns slot validity and hazard flags into an issue decision and the
// consumed count returned to the fetch queue.
// Assumes: slot 1 is never issued unless slot 0 issues (in-order issue).
module dd_pair_classify
    import dd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] slot_valid,
    input  logic       raw,
    input  logic       waw,
    input  logic       mem_clash,
    output pair_kind_e kind,
    output logic [1:0] issue,
    output logic [1:0] consumed
);

    // Priority choice of the pairing outcome for this cycle.
    always_comb begin
        if (!rst_n || !slot_valid[0]) begin
            kind = PK_IDLE;
        end else if (!slot_valid[1]) begin
            kind = PK_SOLO;
        end else if (raw) begin
            kind = PK_SPLIT_RAW;
        end else if (waw) begin
            kind = PK_SPLIT_WAW;
        end else if (mem_clash) begin
            kind = PK_SPLIT_MEM;
        end else begin
            kind = PK_DUAL;
        end
    end

    // Per-lane issue strobes and the queue pop count.
    always_comb begin
        issue[0] = (kind != PK_IDLE);
        issue[1] = (kind == PK_DUAL);
        consumed = slots_taken(kind);
    end

    AST_SOLO_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid == 2'b01) |-> (consumed == 2'd1 && issue == 2'b01)) else $error("solo"); // R6
    AST_EMPTY_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_valid[0] |-> (consumed == 2'd0)) else $error("empty older"); // R9
    AST_RAW_SPLITS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid == 2'b11 && raw) |-> (consumed == 2'd1)) else $error("raw"); // R3
    AST_WAW_SPLITS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid == 2'b11 && waw) |-> (consumed == 2'd1)) else $error("waw"); // R4
    AST_MEM_SPLITS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid == 2'b11 && mem_clash) |-> (consumed == 2'd1)) else $error("mem"); // R5
    AST_COUNT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        consumed == 2'($countones(issue))) else $error("count"); // R2

endmodule

// File: rtl/dd_lane_reg.sv
// Module: dd_lane_reg
// Captures the issued instructions into the lane register that feeds the
// two execution lanes. Lanes that do not issue are cleared.
// Assumes: synchronous active-low reset.
module dd_lane_reg #(
    parameter int REG_IDX_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 issue,
    input  logic [1:0]                 slot_wr_en,
    input  logic [1:0][REG_IDX_W-1:0]  slot_rd,
    input  logic [1:0]                 slot_mem,
    output logic [1:0]                 lane_valid,
    output logic [1:0][REG_IDX_W-1:0]  lane_rd,
    output logic [1:0]                 lane_wr_en,
    output logic                 [1:0] lane_mem
);

    // Load each lane with its slot's fields when it issues, else clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_valid <= '0;
            lane_rd    <= '0;
            lane_wr_en <= '0;
            lane_mem   <= '0;
        end else begin
            for (int l = 0; l < 2; l++) begin
                lane_valid[l] <= issue[l];
                lane_rd[l]    <= issue[l] ? slot_rd[l] : '0;
                lane_wr_en[l] <= issue[l] && slot_wr_en[l];
                lane_mem[l]   <= issue[l] && slot_mem[l];
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (lane_valid == 2'b00 && lane_mem == 2'b00)) else $error("reset"); // R8
    AST_YOUNG_WITH_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid[1] |-> lane_valid[0]) else $error("order"); // R1
    AST_NO_SAME_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid == 2'b11 && lane_wr_en == 2'b11) |-> (lane_rd[0] != lane_rd[1])) else $error("dest"); // R4
    AST_ONE_MEM_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mem != 2'b11) else $error("mem lanes"); // R5

endmodule

// File: rtl/dual_issue_dispatch.sv
// Module: dual_issue_dispatch (top)
// Dispatch dependency checker for a two-way in-order issue stage. Looks at
// the two oldest queue entries, returns how many leave the queue this cycle
// and registers the issued instructions onto two lanes.
// Assumes: the queue is compacted (slot 1 valid implies slot 0 valid in
// normal use) and pops exactly `consumed` entries at each rising edge.
module dual_issue_dispatch
    import dd_pkg::*;
#(
    parameter int REG_IDX_W     = 5,
    parameter int SRC_PER_INSTR = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [1:0]                                   slot_valid,
    input  logic [1:0]                                   slot_wr_en,
    input  logic [1:0][REG_IDX_W-1:0]                    slot_rd,
    input  logic [1:0][SRC_PER_INSTR-1:0]                slot_src_en,
    input  logic [1:0][SRC_PER_INSTR-1:0][REG_IDX_W-1:0] slot_src,
    input  logic [1:0]                                   slot_mem,
    output logic [1:0]                                   consumed,
    output logic [1:0]                                   lane_valid,
    output logic [1:0][REG_IDX_W-1:0]                    lane_rd,
    output logic [1:0]                                   lane_wr_en,
    output logic [1:0]                                   lane_mem
);

    logic       haz_raw;
    logic       haz_waw;
    logic       haz_mem;
    logic [1:0] issue;
    pair_kind_e kind;

    // Hazard comparison of younger against older; slot 0 sources unused here.
    dd_hazard #(
        .REG_IDX_W     (REG_IDX_W),
        .SRC_PER_INSTR (SRC_PER_INSTR)
    ) u_hazard (
        .old_wr_en  (slot_wr_en[0]),
        .old_rd     (slot_rd[0]),
        .old_mem    (slot_mem[0]),
        .yng_wr_en  (slot_wr_en[1]),
        .yng_rd     (slot_rd[1]),
        .yng_src_en (slot_src_en[1]),
        .yng_src    (slot_src[1]),
        .yng_mem    (slot_mem[1]),
        .raw        (haz_raw),
        .waw        (haz_waw),
        .mem_clash  (haz_mem)
    );

    dd_pair_classify u_classify (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_valid (slot_valid),
        .raw        (haz_raw),
        .waw        (haz_waw),
        .mem_clash  (haz_mem),
        .kind       (kind),
        .issue      (issue),
        .consumed   (consumed)
    );

    dd_lane_reg #(
        .REG_IDX_W (REG_IDX_W)
    ) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .slot_wr_en (slot_wr_en),
        .slot_rd    (slot_rd),
        .slot_mem   (slot_mem),
        .lane_valid (lane_valid),
        .lane_rd    (lane_rd),
        .lane_wr_en (lane_wr_en),
        .lane_mem   (lane_mem)
    );

    // Slot 0 source fields are only meaningful to the forwarding network.
    logic unused_src0;
    assign unused_src0 = ^{slot_src_en[0], slot_src[0], kind};

    AST_PAIR_TO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (consumed == 2'd2) |=> (lane_valid == 2'b11)) else $error("pair lanes"); // R7
    AST_ONE_TO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (consumed == 2'd1) |=> (lane_valid == 2'b01)) else $error("single lane"); // R7
    AST_NONE_TO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (consumed == 2'd0) |=> (lane_valid == 2'b00)) else $error("no lane"); // R9

endmodule

// File: tb/dual_issue_dispatch_test.sv
module dual_issue_dispatch_test;

    localparam int AW = 5;
    localparam int NS = 2;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] rd;
        logic          e0;
        logic [AW-1:0] s0;
        logic          e1;
        logic [AW-1:0] s1;
        logic          mem;
    } ins_t;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic [1:0]                   slot_valid = '0;
    logic [1:0]                   slot_wr_en = '0;
    logic [1:0][AW-1:0]           slot_rd = '0;
    logic [1:0][NS-1:0]           slot_src_en = '0;
    logic [1:0][NS-1:0][AW-1:0]   slot_src = '0;
    logic [1:0]                   slot_mem = '0;
    logic [1:0]                   consumed;
    logic [1:0]                   lane_valid;
    logic [1:0][AW-1:0]           lane_rd;
    logic [1:0]                   lane_wr_en;
    logic [1:0]                   lane_mem;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dual_issue_dispatch #(.REG_IDX_W(AW), .SRC_PER_INSTR(NS)) uut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_wr_en(slot_wr_en),
        .slot_rd(slot_rd), .slot_src_en(slot_src_en), .slot_src(slot_src),
        .slot_mem(slot_mem), .consumed(consumed), .lane_valid(lane_valid),
        .lane_rd(lane_rd), .lane_wr_en(lane_wr_en), .lane_mem(lane_mem)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000 && !done) begin
            nerr = nerr + 1;
            nchk = nchk + 1;
            $display("FAIL watchdog actual=%0d expected=<5000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    function automatic ins_t alu(int d, int a, int b);
        return '{1'b1, AW'(d), 1'b1, AW'(a), 1'b1, AW'(b), 1'b0};
    endfunction
    function automatic ins_t ld(int d, int base);
        return '{1'b1, AW'(d), 1'b1, AW'(base), 1'b0, AW'(0), 1'b1};
    endfunction
    function automatic ins_t st(int base, int data);
        return '{1'b0, AW'(0), 1'b1, AW'(base), 1'b1, AW'(data), 1'b1};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nerr = nerr + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(int l, ins_t i);
        slot_valid[l]     = 1'b1;
        slot_wr_en[l]     = i.wr;
        slot_rd[l]        = i.rd;
        slot_src_en[l][0] = i.e0;
        slot_src[l][0]    = i.s0;
        slot_src_en[l][1] = i.e1;
        slot_src[l][1]    = i.s1;
        slot_mem[l]       = i.mem;
    endtask

    task automatic empty(int l);
        slot_valid[l] = 1'b0;
        slot_wr_en[l] = 1'b0;
        slot_mem[l]   = 1'b0;
    endtask

    // Called just after a falling edge with slots driven: checks the
    // same-cycle count, then the lanes after the next rising edge.
    task automatic present(string req, int ecnt, logic [1:0] elv, int rd0, int rd1);
        #1;
        chk(req, "consumed", consumed, ecnt);
        @(posedge clk);
        @(negedge clk);
        chk(req, "lane_valid", lane_valid, elv);
        if (elv[0]) chk(req, "lane_rd0", lane_rd[0], rd0);
        if (elv[1]) chk(req, "lane_rd1", lane_rd[1], rd1);
    endtask

    task automatic t_reset();
        put(0, alu(1, 2, 3));
        put(1, alu(4, 5, 6));
        repeat (3) @(negedge clk);
        #1;
        chk("R8", "consumed in reset", consumed, 0);
        chk("R8", "lane_valid in reset", lane_valid, 0);
        chk("R8", "lane_mem in reset", lane_mem, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_dual_and_single();
        put(0, alu(1, 2, 3)); put(1, alu(4, 5, 6));
        present("R2", 2, 2'b11, 1, 4);
        put(0, alu(7, 8, 9)); empty(1);
        present("R6", 1, 2'b01, 7, 0);
        empty(0); put(1, alu(10, 11, 12));
        present("R9", 0, 2'b00, 0, 0);
    endtask

    task automatic t_raw();
        put(0, alu(5, 1, 2)); put(1, alu(6, 5, 3));
        present("R3", 1, 2'b01, 5, 0);
        put(0, alu(5, 1, 2)); put(1, alu(6, 3, 5));
        present("R3", 1, 2'b01, 5, 0);
        chk("R1", "older lane write enable", lane_wr_en[0], 1);
    endtask

    task automatic t_waw();
        put(0, alu(9, 1, 2)); put(1, alu(9, 3, 4));
        present("R4", 1, 2'b01, 9, 0);
    endtask

    task automatic t_mem();
        put(0, ld(8, 11)); put(1, st(12, 9));
        present("R5", 1, 2'b01, 8, 0);
        chk("R5", "lane_mem split", lane_mem, 2'b01);
        put(0, ld(8, 11)); put(1, alu(13, 9, 10));
        present("R5", 2, 2'b11, 8, 13);
        chk("R5", "lane_mem mixed", lane_mem, 2'b01);
    endtask

    task automatic t_ignore();
        ins_t y;
        y = alu(6, 5, 3);
        y.e0 = 1'b0;               // source matching older dest is not read
        put(0, alu(5, 1, 2)); put(1, y);
        present("R10", 2, 2'b11, 5, 6);
        y = st(20, 21);
        y.mem = 1'b0;              // older writes nothing; younger reads its rd field
        put(0, y); put(1, alu(0, 0, 0));
        present("R10", 2, 2'b11, 0, 0);
    endtask

    task automatic run_seq(string req, ins_t q[6], int ecnt[], int ncyc);
        int h = 0;
        for (int c = 0; c < ncyc; c++) begin
            put(0, q[h]);
            if (h + 1 < 6) put(1, q[h + 1]); else empty(1);
            if (ecnt[c] == 2)
                present(req, 2, 2'b11, q[h].rd, q[h + 1].rd);
            else
                present(req, 1, 2'b01, q[h].rd, 0);
            h += ecnt[c];
        end
        chk(req, "instructions retired", h, 6);
        empty(0); empty(1);
    endtask

    task automatic t_sequences();
        ins_t qa[6];
        ins_t qb[6];
        int ea[] = '{1, 2, 2, 1};
        int eb[] = '{2, 2, 2};
        qa = '{alu(1, 1, 0), alu(2, 1, 1), alu(3, 4, 5), alu(6, 3, 3), ld(8, 11), st(12, 9)};
        qb = '{alu(1, 1, 0), alu(3, 4, 5), alu(2, 1, 1), alu(6, 3, 3), ld(8, 11), alu(13, 9, 10)};
        run_seq("R11", qa, ea, 4);
        run_seq("R11", qb, eb, 3);
    endtask

    task automatic t_mid_reset();
        put(0, alu(1, 2, 3)); put(1, alu(4, 5, 6));
        present("R7", 2, 2'b11, 1, 4);
        rst_n = 1'b0;
        #1;
        chk("R8", "consumed during reset", consumed, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8", "lanes cleared", lane_valid, 0);
        chk("R8", "lane_rd cleared", lane_rd, 0);
        rst_n = 1'b1;
        empty(0); empty(1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_dual_and_single();
        t_raw();
        t_waw();
        t_mem();
        t_ignore();
        t_sequences();
        t_mid_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule